// File: doc/BRIEF.md
# Single-Wire Bus Slave Identity Front End

This block is the slave-side front end of an open-drain, single-wire bus. It runs from a fixed-rate sample clock, where one tick stands for one microsecond by default. It watches the bus, recognises a long master low as a bus reset and answers with a presence pulse. It then decodes the master's time slots: for a write slot it judges the bit from how long the low lasts, and for a read slot it sends a bit by holding the line low or leaving it released.

On top of the bit layer it runs the 8-bit ROM commands against a 64-bit identity supplied on an input. The supported commands are read, match, skip, search, and a search that takes part only while an interrupt is pending. Once a ROM command succeeds, the block enters a memory phase. In that phase it passes every slot, and every assembled byte, to a downstream memory-function layer, and it can send bits that this layer asks for. A slave that loses a match or a search, receives an unknown command, or sees an abandoned slot stays silent until the next reset.

Top module: `ow_rom_slave`

## Requirements
- R1: A line low for at least RST_MIN ticks and then released is a reset. busReset pulses, the block returns to waiting for a ROM command, and a presence low of exactly PD_LEN ticks starts about PD_WAIT ticks after the release.
- R2: A low shorter than RST_MIN ticks produces no presence pulse.
- R3: Write slots are judged by sampling the line SAMPLE_AT ticks after the detected falling edge. A short low (1 to 15 ticks) reads as 1 and a long low (60 to 120 ticks) reads as 0. Bytes travel least significant bit first.
- R4: Command 33h sends all 64 identity bits, romId[0] first. A 0 is sent by holding the line low for DRIVE_LEN ticks and a 1 by leaving it released. The block then enters the memory phase (memActive=1).
- R5: Command 55h followed by 64 bits equal to romId enters the memory phase. Any mismatching bit makes the slave silent with memActive=0 until the next reset.
- R6: Command CCh enters the memory phase at once. memActive is 0 out of reset.
- R7: Command F0h runs 64 search steps, each step being three slots: the identity bit, its complement, then the master's chosen bit. If all choices match, the block enters the memory phase. A choice that differs makes the slave silent.
- R8: Command ECh behaves like F0h while irqPending is 1. With irqPending at 0, the slave stays silent.
- R9: portActive is 0 after reset, stays 0 through the presence pulse, rises at the first master falling edge after it, and is cleared by the next bus reset.
- R10: A low longer than SLOT_MAX ticks, but shorter than a reset, drops any transaction. The slave then ignores traffic (memActive=0, no bytes) until the next reset.
- R11: In the memory phase, each slot pulses memSlot with the sampled bit in memBit, and every eighth bit pulses memByteValid with the LSB-first byte in memByte. With memTxEn=1, the slot sends memTxBit as a read bit.
- R12: An unknown command code leaves the slave silent with memActive=0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one tick per time unit |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Sensed level of the bus |
| romId | input | 64 | Identity, bit 0 sent first |
| irqPending | input | 1 | Unacknowledged interrupt present |
| memTxEn | input | 1 | Memory layer wants to send in the next slot |
| memTxBit | input | 1 | Bit to send when memTxEn is 1 |
| lineDrvLow | output | 1 | Pull the bus low (open-drain enable) |
| portActive | output | 1 | Bus port claimed since last presence |
| busReset | output | 1 | One-tick pulse when a reset is recognised |
| memActive | output | 1 | ROM phase finished, memory phase open |
| memSlot | output | 1 | One-tick pulse per memory-phase slot |
| memBit | output | 1 | Bit sampled in that slot |
| memByteValid | output | 1 | One-tick pulse when a byte completes |
| memByte | output | 8 | Completed byte, LSB received first |

## Verification
The bench targets the points where a slave most easily goes wrong.

- Search arbitration. A run that follows the identity to the end checks the bit/complement pairs. A run that diverges mid-way checks that the slave drops out; a slave that kept going would pull later bits low.
- Interrupt-gated search. A slave that ignored the gate would answer without a pending interrupt.
- Failed match. The match is made to fail on one deep bit. A slave that checked only part of the identity would wrongly enter the memory phase.
- Long lows. A low shorter than a reset must give no presence. A low past the slot limit must end the transaction, so a block that sampled it as an ordinary 0 would keep streaming bytes.
- Port claim. The bench checks when the port counts as claimed: a block that claimed it at the presence pulse would show portActive too early.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;

  localparam logic [7:0] CMD_READ_ID    = 8'h33;
  localparam logic [7:0] CMD_MATCH_ID   = 8'h55;
  localparam logic [7:0] CMD_SKIP_ID    = 8'hCC;
  localparam logic [7:0] CMD_SEARCH_ID  = 8'hF0;
  localparam logic [7:0] CMD_SEARCH_IRQ = 8'hEC;

  // events from the line datapath to the control
  typedef struct packed {
    logic busReset;
    logic bitEv;
    logic bitVal;
    logic slotLong;
  } lineEv_t;

  // strobes from the control to the line datapath, latched at each slot start
  typedef struct packed {
    logic rdSlot;
    logic rdZero;
  } lineCtl_t;

  typedef enum logic [1:0] {PD_OFF, PD_HOLD, PD_DRIVE} pdPh_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_MEM, ST_LOST
  } romSt_t;

endpackage

// File: rtl/ow_line_dp.sv
module ow_line_dp
  import ow_rom_pkg::*;
#(
  parameter int RST_MIN   = 480,
  parameter int PD_WAIT   = 30,
  parameter int PD_LEN    = 120,
  parameter int SAMPLE_AT = 30,
  parameter int DRIVE_LEN = 30,
  parameter int SLOT_MAX  = 121
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineIn,
  input  lineCtl_t ctl,
  output lineEv_t  ev,
  output logic     lineDrvLow,
  output logic     portActive
);

  localparam int SLOT_END = (SAMPLE_AT > DRIVE_LEN) ? SAMPLE_AT : DRIVE_LEN;
  localparam int PD_MAX   = (PD_WAIT > PD_LEN) ? PD_WAIT : PD_LEN;
  localparam int T_MAX    = (SLOT_END > PD_MAX) ? SLOT_END : PD_MAX;
  localparam int LW       = $clog2(RST_MIN + 1);
  localparam int TW       = $clog2(T_MAX + 1);

  logic          syncA, syncB, prevLine;
  logic [LW-1:0] lowCnt;
  pdPh_t         pdPh;
  logic [TW-1:0] pdCnt;
  logic          awaitFirst;
  logic          slotOn, slotDrv;
  logic [TW-1:0] slotCnt;

  logic fallEdge, riseEdge, rstHit, slotFall;

  // two-flop synchroniser plus one stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      prevLine <= 1'b1;
    end else begin
      syncA    <= lineIn;
      syncB    <= syncA;
      prevLine <= syncB;
    end
  end

  assign fallEdge = prevLine & ~syncB;
  assign riseEdge = ~prevLine & syncB;
  assign rstHit   = riseEdge && (lowCnt == LW'(RST_MIN)) && (pdPh == PD_OFF);
  assign slotFall = fallEdge && (pdPh == PD_OFF);

  // length of the current low, saturating at the reset threshold
  always_ff @(posedge clk) begin
    if (!rstN) lowCnt <= '0;
    else if (syncB || pdPh != PD_OFF) lowCnt <= '0;
    else if (lowCnt != LW'(RST_MIN)) lowCnt <= lowCnt + 1'b1;
  end

  // presence sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pdPh  <= PD_OFF;
      pdCnt <= '0;
    end else if (rstHit) begin
      pdPh  <= PD_HOLD;
      pdCnt <= '0;
    end else begin
      unique case (pdPh)
        PD_HOLD: begin
          if (pdCnt == TW'(PD_WAIT - 1)) begin
            pdPh  <= PD_DRIVE;
            pdCnt <= '0;
          end else pdCnt <= pdCnt + 1'b1;
        end
        PD_DRIVE: begin
          if (pdCnt == TW'(PD_LEN - 1)) begin
            pdPh  <= PD_OFF;
            pdCnt <= '0;
          end else pdCnt <= pdCnt + 1'b1;
        end
        default: pdCnt <= '0;
      endcase
    end
  end

  // port claim: first master fall after the presence pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      awaitFirst <= 1'b0;
      portActive <= 1'b0;
    end else if (rstHit) begin
      awaitFirst <= 1'b0;
      portActive <= 1'b0;
    end else begin
      if (pdPh == PD_DRIVE && pdCnt == TW'(PD_LEN - 1)) awaitFirst <= 1'b1;
      if (slotFall && awaitFirst) begin
        awaitFirst <= 1'b0;
        portActive <= 1'b1;
      end
    end
  end

  // slot timer: sampling point and read-zero hold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotOn  <= 1'b0;
      slotDrv <= 1'b0;
      slotCnt <= '0;
    end else if (slotFall) begin
      slotOn  <= 1'b1;
      slotDrv <= ctl.rdSlot & ctl.rdZero;
      slotCnt <= '0;
    end else if (slotOn) begin
      slotCnt <= slotCnt + 1'b1;
      if (slotCnt == TW'(DRIVE_LEN - 1)) slotDrv <= 1'b0;
      if (slotCnt == TW'(SLOT_END - 1))  slotOn  <= 1'b0;
    end
  end

  always_comb begin
    ev.busReset = rstHit;
    ev.bitEv    = slotOn && (slotCnt == TW'(SAMPLE_AT - 1));
    ev.bitVal   = syncB;
    ev.slotLong = ~syncB && (pdPh == PD_OFF) && (lowCnt == LW'(SLOT_MAX));
  end

  assign lineDrvLow = (pdPh == PD_DRIVE) | slotDrv;

endmodule

// File: rtl/ow_rom_ctl.sv
module ow_rom_ctl
  import ow_rom_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  lineEv_t         ev,
  input  logic [ID_W-1:0] romId,
  input  logic            irqPending,
  input  logic            memTxEn,
  input  logic            memTxBit,
  output lineCtl_t        ctl,
  output logic            memActive,
  output logic            memSlot,
  output logic            memBit,
  output logic            memByteValid,
  output logic [7:0]      memByte
);

  localparam int IW = $clog2(ID_W);

  romSt_t        state;
  logic [IW-1:0] idx;
  logic [7:0]    cmdSh;
  logic [1:0]    srchPh;
  logic          srchIrq;
  logic [7:0]    memSh;
  logic [2:0]    memCnt;

  logic          lastBit, idBit, srchOk;
  logic [7:0]    cmdNext, memNext;

  assign lastBit = (idx == IW'(ID_W - 1));
  assign idBit   = romId[idx];
  assign cmdNext = {ev.bitVal, cmdSh[7:1]};
  assign memNext = {ev.bitVal, memSh[7:1]};
  assign srchOk  = !srchIrq || irqPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      idx          <= '0;
      cmdSh        <= '0;
      srchPh       <= '0;
      srchIrq      <= 1'b0;
      memSh        <= '0;
      memCnt       <= '0;
      memSlot      <= 1'b0;
      memBit       <= 1'b0;
      memByteValid <= 1'b0;
      memByte      <= '0;
    end else begin
      memSlot      <= 1'b0;
      memByteValid <= 1'b0;
      if (ev.busReset) begin
        state   <= ST_CMD;
        idx     <= '0;
        srchPh  <= '0;
        srchIrq <= 1'b0;
        memCnt  <= '0;
      end else if (ev.slotLong && state != ST_IDLE) begin
        state <= ST_LOST;
      end else if (ev.bitEv) begin
        unique case (state)
          ST_CMD: begin
            cmdSh <= cmdNext;
            if (idx[2:0] == 3'd7) begin
              idx <= '0;
              unique case (cmdNext)
                CMD_READ_ID:    state <= ST_READ;
                CMD_MATCH_ID:   state <= ST_MATCH;
                CMD_SKIP_ID:    state <= ST_MEM;
                CMD_SEARCH_ID:  state <= ST_SEARCH;
                CMD_SEARCH_IRQ: begin
                  srchIrq <= 1'b1;
                  state   <= irqPending ? ST_SEARCH : ST_LOST;
                end
                default:        state <= ST_LOST;
              endcase
            end else idx <= idx + 1'b1;
          end
          ST_READ: begin
            if (lastBit) state <= ST_MEM;
            else idx <= idx + 1'b1;
          end
          ST_MATCH: begin
            if (ev.bitVal != idBit) state <= ST_LOST;
            else if (lastBit) state <= ST_MEM;
            else idx <= idx + 1'b1;
          end
          ST_SEARCH: begin
            if (srchPh != 2'd2) srchPh <= srchPh + 1'b1;
            else begin
              srchPh <= '0;
              if (ev.bitVal != idBit || !srchOk) state <= ST_LOST;
              else if (lastBit) state <= ST_MEM;
              else idx <= idx + 1'b1;
            end
          end
          ST_MEM: begin
            memSh   <= memNext;
            memCnt  <= memCnt + 1'b1;
            memSlot <= 1'b1;
            memBit  <= ev.bitVal;
            if (memCnt == 3'd7) begin
              memByte      <= memNext;
              memByteValid <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    ctl.rdSlot = 1'b0;
    ctl.rdZero = 1'b0;
    unique case (state)
      ST_READ: begin
        ctl.rdSlot = 1'b1;
        ctl.rdZero = ~idBit;
      end
      ST_SEARCH: begin
        ctl.rdSlot = (srchPh != 2'd2) && srchOk;
        ctl.rdZero = (srchPh == 2'd0) ? ~idBit : idBit;
      end
      ST_MEM: begin
        ctl.rdSlot = memTxEn;
        ctl.rdZero = ~memTxBit;
      end
      default: ;
    endcase
  end

  assign memActive = (state == ST_MEM);

endmodule

// File: rtl/ow_rom_slave.sv
module ow_rom_slave
  import ow_rom_pkg::*;
#(
  parameter int RST_MIN   = 480,
  parameter int PD_WAIT   = 30,
  parameter int PD_LEN    = 120,
  parameter int SAMPLE_AT = 30,
  parameter int DRIVE_LEN = 30,
  parameter int SLOT_MAX  = 121,
  parameter int ID_W      = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lineIn,
  input  logic [ID_W-1:0] romId,
  input  logic            irqPending,
  input  logic            memTxEn,
  input  logic            memTxBit,
  output logic            lineDrvLow,
  output logic            portActive,
  output logic            busReset,
  output logic            memActive,
  output logic            memSlot,
  output logic            memBit,
  output logic            memByteValid,
  output logic [7:0]      memByte
);

  lineEv_t  lineEv;
  lineCtl_t lineCtl;

  ow_line_dp #(
    .RST_MIN(RST_MIN), .PD_WAIT(PD_WAIT), .PD_LEN(PD_LEN),
    .SAMPLE_AT(SAMPLE_AT), .DRIVE_LEN(DRIVE_LEN), .SLOT_MAX(SLOT_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .ctl(lineCtl), .ev(lineEv),
    .lineDrvLow(lineDrvLow), .portActive(portActive)
  );

  ow_rom_ctl #(.ID_W(ID_W)) u_ctl (
    .clk(clk), .rstN(rstN), .ev(lineEv), .romId(romId),
    .irqPending(irqPending), .memTxEn(memTxEn), .memTxBit(memTxBit),
    .ctl(lineCtl), .memActive(memActive), .memSlot(memSlot), .memBit(memBit),
    .memByteValid(memByteValid), .memByte(memByte)
  );

  assign busReset = lineEv.busReset;

endmodule

// File: rtl/ow_rom_slave_chk.sv
module ow_rom_slave_chk #(
  parameter int PD_LEN    = 120,
  parameter int DRIVE_LEN = 30
) (
  input logic clk,
  input logic rstN,
  input logic lineDrvLow,
  input logic busReset,
  input logic portActive,
  input logic memActive,
  input logic memSlot,
  input logic memByteValid
);

  localparam int MAXRUN = (PD_LEN > DRIVE_LEN) ? PD_LEN : DRIVE_LEN;
  localparam int RW     = $clog2(MAXRUN + 2);

  logic [RW-1:0] drvRun;

  always_ff @(posedge clk) begin
    if (!rstN) drvRun <= '0;
    else if (!lineDrvLow) drvRun <= '0;
    else if (drvRun != RW'(MAXRUN + 1)) drvRun <= drvRun + 1'b1;
  end

  assert_drive_bounded_R1: assert property (@(posedge clk) disable iff (!rstN)
    drvRun <= RW'(MAXRUN));

  assert_reset_to_cmd_R1: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !memActive);

  assert_reset_drops_port_R9: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !portActive);

  assert_slot_in_mem_R11: assert property (@(posedge clk) disable iff (!rstN)
    memSlot |-> $past(memActive));

  assert_byte_with_slot_R11: assert property (@(posedge clk) disable iff (!rstN)
    memByteValid |-> memSlot);

endmodule

bind ow_rom_slave ow_rom_slave_chk #(.PD_LEN(PD_LEN), .DRIVE_LEN(DRIVE_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .lineDrvLow(lineDrvLow), .busReset(busReset),
  .portActive(portActive), .memActive(memActive), .memSlot(memSlot),
  .memByteValid(memByteValid)
);

// File: tb/tb_ow_rom_slave.sv
module tb_ow_rom_slave;

  localparam int PD_WAIT = 30;
  localparam int PD_LEN  = 120;
  localparam logic [63:0] ID = 64'h9E_1F2A3B4C5D6E_04;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterLow = 1'b0;
  logic irqPending = 1'b0;
  logic memTxEn = 1'b0;
  logic memTxBit = 1'b1;
  logic busLine;
  logic lineDrvLow, portActive, busReset, memActive, memSlot, memBit, memByteValid;
  logic [7:0] memByte;

  int total = 0;
  int bad = 0;
  int rstSeen = 0;
  bit done = 1'b0;
  logic [7:0] byteQ[$];

  always #10 clk = ~clk;

  assign busLine = ~masterLow & ~lineDrvLow;

  ow_rom_slave dut (
    .clk(clk), .rstN(rstN), .lineIn(busLine), .romId(ID),
    .irqPending(irqPending), .memTxEn(memTxEn), .memTxBit(memTxBit),
    .lineDrvLow(lineDrvLow), .portActive(portActive), .busReset(busReset),
    .memActive(memActive), .memSlot(memSlot), .memBit(memBit),
    .memByteValid(memByteValid), .memByte(memByte)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busRst(output int pdStart, output int pdLen);
    pdStart = -1;
    pdLen = 0;
    masterLow = 1'b1;
    idle(500);
    masterLow = 1'b0;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (lineDrvLow) begin
        if (pdStart < 0) pdStart = t;
        pdLen++;
      end
    end
  endtask

  task automatic quickRst();
    int s, l;
    busRst(s, l);
  endtask

  task automatic writeBit(input bit b);
    masterLow = 1'b1;
    idle(b ? 6 : 80);
    masterLow = 1'b0;
    idle(b ? 94 : 20);
  endtask

  task automatic writeByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) writeBit(v[i]);
  endtask

  task automatic readBit(output bit b);
    masterLow = 1'b1;
    idle(2);
    masterLow = 1'b0;
    idle(13);
    b = busLine;
    idle(85);
  endtask

  // scoreboard monitor: memory-phase bytes against the expected queue (R3, R11)
  always @(negedge clk) begin
    if (busReset) rstSeen++;
    if (memByteValid) begin
      if (byteQ.size() == 0) check(1'b0, "R11 unexpected byte", memByte, 0);
      else begin
        logic [7:0] e;
        e = byteQ.pop_front();
        check(memByte == e, "R3/R11 byte", memByte, e);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pdS, pdL, cnt, rs0, good;
    bit a, b;
    logic [63:0] got;

    idle(5);
    rstN = 1'b1;
    idle(3);
    check(lineDrvLow == 0, "R1 idle after reset", lineDrvLow, 0);
    check(portActive == 0, "R9 portActive after reset", portActive, 0);
    check(memActive == 0, "R6 memActive after reset", memActive, 0);

    // R2: short low, no presence
    masterLow = 1'b1;
    idle(300);
    masterLow = 1'b0;
    cnt = 0;
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      if (lineDrvLow) cnt++;
    end
    check(cnt == 0, "R2 no presence after short low", cnt, 0);

    // R1: reset and presence timing
    rs0 = rstSeen;
    busRst(pdS, pdL);
    check(pdS >= PD_WAIT && pdS <= PD_WAIT + 6, "R1 presence start", pdS, PD_WAIT);
    check(pdL == PD_LEN, "R1 presence length", pdL, PD_LEN);
    check(rstSeen == rs0 + 1, "R1 busReset pulse", rstSeen - rs0, 1);
    check(portActive == 0, "R9 not claimed at presence", portActive, 0);

    // R6 skip, R9 claim, R3 write slots
    writeBit(1'b0);
    check(portActive == 1, "R9 claimed at first fall", portActive, 1);
    for (int i = 1; i < 8; i++) writeBit(CMDSKIP[i]);
    check(memActive == 1, "R6 skip enters memory phase", memActive, 1);
    byteQ.push_back(8'hA5);
    byteQ.push_back(8'h3C);
    writeByte(8'hA5);
    writeByte(8'h3C);
    idle(20);
    check(byteQ.size() == 0, "R3 bytes delivered", byteQ.size(), 0);

    // R10: abandoned slot
    masterLow = 1'b1;
    idle(200);
    masterLow = 1'b0;
    idle(100);
    check(memActive == 0, "R10 long low drops transaction", memActive, 0);
    writeByte(8'hFF);
    check(memActive == 0, "R10 stays silent", memActive, 0);

    // R4: read identity
    quickRst();
    writeByte(8'h33);
    got = '0;
    for (int i = 0; i < 64; i++) begin
      readBit(a);
      got[i] = a;
    end
    check(got == ID, "R4 identity read", got, ID);
    check(memActive == 1, "R4 memory phase after read", memActive, 1);
    memTxEn = 1'b1;
    memTxBit = 1'b0;
    readBit(a);
    check(a == 1'b0, "R11 send zero", a, 0);
    memTxBit = 1'b1;
    readBit(a);
    check(a == 1'b1, "R11 send one", a, 1);
    memTxEn = 1'b0;

    // R5: match ok and fail
    quickRst();
    writeByte(8'h55);
    for (int i = 0; i < 64; i++) writeBit(ID[i]);
    check(memActive == 1, "R5 match accepted", memActive, 1);
    quickRst();
    writeByte(8'h55);
    for (int i = 0; i < 64; i++) writeBit(ID[i] ^ (i == 40));
    check(memActive == 0, "R5 mismatch rejected", memActive, 0);
    readBit(a);
    check(a == 1'b1, "R5 silent after mismatch", a, 1);

    // R7: full search
    quickRst();
    writeByte(8'hF0);
    good = 0;
    for (int i = 0; i < 64; i++) begin
      readBit(a);
      readBit(b);
      if (a == ID[i] && b == ~ID[i]) good++;
      writeBit(ID[i]);
    end
    check(good == 64, "R7 search pairs", good, 64);
    check(memActive == 1, "R7 search completes", memActive, 1);

    // R7: diverging search
    quickRst();
    writeByte(8'hF0);
    for (int i = 0; i < 6; i++) begin
      readBit(a);
      readBit(b);
      writeBit(i == 5 ? ~ID[i] : ID[i]);
    end
    readBit(a);
    readBit(b);
    check({a, b} == 2'b11, "R7 dropped out", {a, b}, 2'b11);
    check(memActive == 0, "R7 no memory phase", memActive, 0);

    // R8: interrupt search
    quickRst();
    writeByte(8'hEC);
    readBit(a);
    readBit(b);
    check({a, b} == 2'b11, "R8 silent without irq", {a, b}, 2'b11);
    irqPending = 1'b1;
    quickRst();
    writeByte(8'hEC);
    readBit(a);
    readBit(b);
    check({a, b} == {ID[0], ~ID[0]}, "R8 answers with irq", {a, b}, {ID[0], ~ID[0]});
    irqPending = 1'b0;

    // R12: unknown command
    quickRst();
    writeByte(8'h99);
    readBit(a);
    check(a == 1'b1, "R12 silent after unknown", a, 1);
    check(memActive == 0, "R12 no memory phase", memActive, 0);

    idle(20);
    check(byteQ.size() == 0, "R11 scoreboard drained", byteQ.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [7:0] CMDSKIP = 8'hCC;

endmodule